// File: doc/BRIEF.md
# Interrupt acceptance and vector unit

This block decides, at each instruction boundary of an 8-bit processor, whether an interrupt is taken, and forms the address control goes to. It keeps two interrupt-enable flags: a live enable (`iff1_o`) and a saved copy (`iff2_o`). It also keeps a two-bit interrupt-mode register. A non-maskable request arrives as a falling edge on `nmi_ni`. A maskable request is an active-low level on `int_req_ni` that is already synchronised. Instruction decode supplies one-cycle strobes for enable, disable, mode select and return-from-NMI.

A taken non-maskable interrupt saves the live enable into the copy and clears the live enable. It goes to the fixed address 0x0066 and needs no bus acknowledge. A taken maskable interrupt clears both flags and opens a one-cycle acknowledge window, during which the device drives a byte. The unit turns that byte into a target according to the mode:
- a restart opcode (mode 0),
- ignored in favour of 0x0038 (mode 1),
- the low half of a vector-table pointer whose high half is the page register (mode 2).

Pushing the return address and reading the table belong to the surrounding core.

Top module: `intr_ctrl`

## Requirements
- R1: After reset both enable flags are 0, the mode is 0, and `ack_o`, `take_o` and `take_nmi_o` are 0.
- R2: An enable strobe sets both flags to 1; a disable strobe clears both to 0, one cycle after the strobe.
- R3: The mode strobes select mode 0, 1 or 2, reported on `mode_o` as 2'd0, 2'd1, 2'd2.
- R4: A maskable request is accepted only in a cycle with `boundary_i` high, `int_req_ni` low and `iff1_o` high. After the accepting edge, `ack_o` is high for exactly one cycle and both flags are 0. In the cycle after that, `take_o` pulses with `take_nmi_o` low.
- R5: In mode 1 the target is 0x0038 whatever byte the device drives, and `via_table_o` and `bad_op_o` are 0.
- R6: In mode 2 the target is {page_i, device byte}, both sampled during the acknowledge cycle, and `via_table_o` is 1.
- R7: In mode 0 the target is the device byte ANDed with 0x38, zero-extended. `bad_op_o` is 1 exactly when the byte ANDed with 0xC7 differs from 0xC7 (not a restart opcode). `via_table_o` is 0.
- R8: A falling edge on `nmi_ni` is held pending. At the next boundary, `take_o` and `take_nmi_o` pulse with target 0x0066 and no acknowledge, `iff2_o` takes the old `iff1_o`, and `iff1_o` becomes 0. Holding `nmi_ni` low triggers only once.
- R9: A return-from-NMI strobe copies `iff2_o` into `iff1_o`.
- R10: When a non-maskable interrupt is pending at a boundary where a maskable request would also be accepted, the non-maskable one is taken. Maskable requests are then refused while `iff1_o` stays 0.
- R11: A second non-maskable interrupt taken inside the first handler overwrites `iff2_o` with the cleared live enable, so a later return-from-NMI leaves `iff1_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary, acceptance point |
| int_req_ni | input | 1 | Maskable request, active low |
| nmi_ni | input | 1 | Non-maskable request, falling edge active |
| op_ei_i | input | 1 | Enable-interrupts strobe |
| op_di_i | input | 1 | Disable-interrupts strobe |
| op_im0_i | input | 1 | Select mode 0 |
| op_im1_i | input | 1 | Select mode 1 |
| op_im2_i | input | 1 | Select mode 2 |
| op_retn_i | input | 1 | Return-from-NMI strobe |
| page_i | input | 8 | Vector page register value |
| dev_byte_i | input | 8 | Byte driven by the device during acknowledge |
| ack_o | output | 1 | Acknowledge window to the device |
| take_o | output | 1 | Take-interrupt pulse |
| take_nmi_o | output | 1 | The taken interrupt is non-maskable |
| target_o | output | 16 | Service address or table pointer |
| via_table_o | output | 1 | `target_o` is a table pointer |
| bad_op_o | output | 1 | Mode 0 byte is not a restart opcode |
| iff1_o | output | 1 | Live maskable enable |
| iff2_o | output | 1 | Saved enable copy |
| mode_o | output | 2 | Current interrupt mode |

## Verification
The bench goes after the flag swap around nested non-maskable interrupts. A design that restores from the live flag, or that does not overwrite the copy on the second entry, would re-enable interrupts after the return. It drives a request with both kinds pending together, to catch a unit that acknowledges the device while taking the non-maskable path. It holds `nmi_ni` low across several boundaries, to catch a level-sensitive detector that keeps re-entering the handler. Random mode 0 and mode 2 bytes probe the restart decode and the pointer halves, where a swapped half or a wrong mask shows up in `target_o` or `bad_op_o`.

// File: rtl/intr_pkg.sv
package intr_pkg;
   typedef enum logic [1:0] {
      MODE_RST   = 2'd0,
      MODE_FIXED = 2'd1,
      MODE_TABLE = 2'd2
   } intr_mode_t;
endpackage

// File: rtl/intr_nmi_edge.sv
module intr_nmi_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic nmi_ni,
   input  logic clr_i,
   output logic pend_o
);
   logic nmi_q;
   logic fall_w;

   assign fall_w = nmi_q & ~nmi_ni;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         nmi_q  <= 1'b1;
         pend_o <= 1'b0;
      end else begin
         nmi_q <= nmi_ni;
         if (fall_w)     pend_o <= 1'b1;
         else if (clr_i) pend_o <= 1'b0;
      end
   end
endmodule

// File: rtl/intr_flags.sv
module intr_flags
   import intr_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       nmi_take_i,
   input  logic       mi_take_i,
   input  logic       ei_i,
   input  logic       di_i,
   input  logic       retn_i,
   input  logic       im0_i,
   input  logic       im1_i,
   input  logic       im2_i,
   output logic       iff1_o,
   output logic       iff2_o,
   output intr_mode_t mode_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         iff1_o <= 1'b0;
         iff2_o <= 1'b0;
         mode_o <= MODE_RST;
      end else begin
         if (nmi_take_i) begin
            iff2_o <= iff1_o;
            iff1_o <= 1'b0;
         end else if (mi_take_i) begin
            iff1_o <= 1'b0;
            iff2_o <= 1'b0;
         end else if (ei_i) begin
            iff1_o <= 1'b1;
            iff2_o <= 1'b1;
         end else if (di_i) begin
            iff1_o <= 1'b0;
            iff2_o <= 1'b0;
         end else if (retn_i) begin
            iff1_o <= iff2_o;
         end
         if (im2_i)      mode_o <= MODE_TABLE;
         else if (im1_i) mode_o <= MODE_FIXED;
         else if (im0_i) mode_o <= MODE_RST;
      end
   end
endmodule

// File: rtl/intr_vector.sv
module intr_vector
   import intr_pkg::*;
#(
   parameter int unsigned              DATA_W     = 8,
   parameter int unsigned              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]        FIXED_ADDR = 16'h0038,
   parameter logic [DATA_W-1:0]        RST_SEL    = 8'h38,
   parameter logic [DATA_W-1:0]        RST_OPMASK = 8'hC7
) (
   input  intr_mode_t        mode_i,
   input  logic [DATA_W-1:0] page_i,
   input  logic [DATA_W-1:0] dev_i,
   output logic [ADDR_W-1:0] vec_o,
   output logic              table_o,
   output logic              bad_o
);
   localparam int unsigned PAD_W = ADDR_W - DATA_W;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         initial $error("intr_vector: ADDR_W must be twice DATA_W");
      end
   endgenerate

   always_comb begin
      vec_o   = FIXED_ADDR;
      table_o = 1'b0;
      bad_o   = 1'b0;
      unique case (mode_i)
         MODE_TABLE: begin
            vec_o   = {page_i, dev_i};
            table_o = 1'b1;
         end
         MODE_FIXED: vec_o = FIXED_ADDR;
         default: begin
            vec_o = {{PAD_W{1'b0}}, dev_i & RST_SEL};
            bad_o = (dev_i & RST_OPMASK) != RST_OPMASK;
         end
      endcase
   end
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
   import intr_pkg::*;
#(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] NMI_ADDR   = 16'h0066,
   parameter logic [ADDR_W-1:0] FIXED_ADDR = 16'h0038
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              boundary_i,
   input  logic              int_req_ni,
   input  logic              nmi_ni,
   input  logic              op_ei_i,
   input  logic              op_di_i,
   input  logic              op_im0_i,
   input  logic              op_im1_i,
   input  logic              op_im2_i,
   input  logic              op_retn_i,
   input  logic [DATA_W-1:0] page_i,
   input  logic [DATA_W-1:0] dev_byte_i,
   output logic              ack_o,
   output logic              take_o,
   output logic              take_nmi_o,
   output logic [ADDR_W-1:0] target_o,
   output logic              via_table_o,
   output logic              bad_op_o,
   output logic              iff1_o,
   output logic              iff2_o,
   output logic [1:0]        mode_o
);
   generate
      if (DATA_W < 8) begin : g_small_data
         initial $error("intr_ctrl: DATA_W must be at least 8");
      end
   endgenerate

   logic              nmi_pend;
   logic              nmi_go;
   logic              mi_go;
   logic              ack_q;
   intr_mode_t        mode;
   logic [ADDR_W-1:0] vec_w;
   logic              table_w;
   logic              bad_w;

   assign nmi_go = boundary_i & nmi_pend & ~ack_q;
   assign mi_go  = boundary_i & ~int_req_ni & iff1_o & ~nmi_pend & ~ack_q;

   intr_nmi_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .nmi_ni (nmi_ni),
      .clr_i  (nmi_go),
      .pend_o (nmi_pend)
   );

   intr_flags u_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .nmi_take_i (nmi_go),
      .mi_take_i  (mi_go),
      .ei_i       (op_ei_i),
      .di_i       (op_di_i),
      .retn_i     (op_retn_i),
      .im0_i      (op_im0_i),
      .im1_i      (op_im1_i),
      .im2_i      (op_im2_i),
      .iff1_o     (iff1_o),
      .iff2_o     (iff2_o),
      .mode_o     (mode)
   );

   intr_vector #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .FIXED_ADDR (FIXED_ADDR),
      .RST_SEL    (DATA_W'(8'h38)),
      .RST_OPMASK (DATA_W'(8'hC7))
   ) u_vec (
      .mode_i  (mode),
      .page_i  (page_i),
      .dev_i   (dev_byte_i),
      .vec_o   (vec_w),
      .table_o (table_w),
      .bad_o   (bad_w)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ack_q       <= 1'b0;
         take_o      <= 1'b0;
         take_nmi_o  <= 1'b0;
         target_o    <= '0;
         via_table_o <= 1'b0;
         bad_op_o    <= 1'b0;
      end else begin
         ack_q      <= mi_go;
         take_o     <= nmi_go | ack_q;
         take_nmi_o <= nmi_go;
         if (nmi_go) begin
            target_o    <= NMI_ADDR;
            via_table_o <= 1'b0;
            bad_op_o    <= 1'b0;
         end else if (ack_q) begin
            target_o    <= vec_w;
            via_table_o <= table_w;
            bad_op_o    <= bad_w;
         end
      end
   end

   assign ack_o  = ack_q;
   assign mode_o = mode;
endmodule

// File: rtl/intr_ctrl_chk.sv
module intr_ctrl_chk #(
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] NMI_ADDR = 16'h0066
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              boundary_i,
   input logic              int_req_ni,
   input logic [DATA_W-1:0] page_i,
   input logic              ack_o,
   input logic              take_o,
   input logic              take_nmi_o,
   input logic [ADDR_W-1:0] target_o,
   input logic              via_table_o,
   input logic              iff1_o,
   input logic              iff2_o
);
   AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ack_o) |-> $past(iff1_o) && $past(boundary_i) && !$past(int_req_ni)); // R4
   AST_ACK_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ack_o) |-> !iff1_o && !iff2_o); // R4
   AST_ACK_THEN_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |=> take_o && !take_nmi_o && !ack_o); // R4
   AST_ACK_TAKE_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ack_o, take_o})); // R8
   AST_NMI_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_nmi_o |-> take_o && target_o == NMI_ADDR && !via_table_o); // R8
   AST_NMI_FLAG_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(take_nmi_o) |-> !iff1_o && iff2_o == $past(iff1_o)); // R8
   AST_TABLE_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o && via_table_o |-> target_o[ADDR_W-1:DATA_W] == $past(page_i)); // R6
endmodule

bind intr_ctrl intr_ctrl_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NMI_ADDR (NMI_ADDR)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .boundary_i  (boundary_i),
   .int_req_ni  (int_req_ni),
   .page_i      (page_i),
   .ack_o       (ack_o),
   .take_o      (take_o),
   .take_nmi_o  (take_nmi_o),
   .target_o    (target_o),
   .via_table_o (via_table_o),
   .iff1_o      (iff1_o),
   .iff2_o      (iff2_o)
);

// File: tb/intr_ctrl_tb_top.sv
module intr_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic boundary = 1'b0, int_req_n = 1'b1, nmi_n = 1'b1;
   logic ei = 1'b0, di = 1'b0, im0 = 1'b0, im1 = 1'b0, im2 = 1'b0, retn = 1'b0;
   logic [7:0] page = 8'h00, dev = 8'h00;
   logic ack, take, take_nmi, via_table, bad_op, iff1, iff2;
   logic [15:0] target;
   logic [1:0] mode;
   int total = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   intr_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .int_req_ni(int_req_n),
      .nmi_ni(nmi_n), .op_ei_i(ei), .op_di_i(di), .op_im0_i(im0), .op_im1_i(im1),
      .op_im2_i(im2), .op_retn_i(retn), .page_i(page), .dev_byte_i(dev),
      .ack_o(ack), .take_o(take), .take_nmi_o(take_nmi), .target_o(target),
      .via_table_o(via_table), .bad_op_o(bad_op), .iff1_o(iff1), .iff2_o(iff2),
      .mode_o(mode)
   );

   task automatic step;
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_target(input int m, input logic [7:0] p, input logic [7:0] d);
      if (m == 2) return {p, d};
      if (m == 1) return 16'h0038;
      return {8'h00, d & 8'h38};
   endfunction

   function automatic logic exp_bad(input int m, input logic [7:0] d);
      return (m == 0) && ((d & 8'hC7) != 8'hC7);
   endfunction

   task automatic pulse_ei;  ei = 1'b1;   step; ei = 1'b0;   endtask
   task automatic pulse_di;  di = 1'b1;   step; di = 1'b0;   endtask
   task automatic pulse_retn; retn = 1'b1; step; retn = 1'b0; endtask
   task automatic set_mode(input int m);
      im0 = (m == 0); im1 = (m == 1); im2 = (m == 2);
      step;
      im0 = 1'b0; im1 = 1'b0; im2 = 1'b0;
   endtask

   // maskable request through acknowledge; returns ack seen after accept edge
   task automatic do_mi(input logic [7:0] d, output logic ack_seen);
      int_req_n = 1'b0; boundary = 1'b1;
      step;
      ack_seen = ack;
      boundary = 1'b0; int_req_n = 1'b1; dev = d;
      step;
   endtask

   task automatic do_nmi;
      nmi_n = 1'b0;
      step;
      boundary = 1'b1;
      step;
      boundary = 1'b0;
   endtask

   initial begin
      logic a;
      repeat (3) step;
      chk("R1 iff1", iff1, 0); chk("R1 iff2", iff2, 0); chk("R1 mode", mode, 0);
      chk("R1 ack", ack, 0); chk("R1 take", take, 0); chk("R1 take_nmi", take_nmi, 0);
      rst_n = 1'b1;
      step;

      pulse_ei; chk("R2 ei iff1", iff1, 1); chk("R2 ei iff2", iff2, 1);
      pulse_di; chk("R2 di iff1", iff1, 0); chk("R2 di iff2", iff2, 0);

      set_mode(1); chk("R3 mode1", mode, 1);
      set_mode(2); chk("R3 mode2", mode, 2);
      set_mode(0); chk("R3 mode0", mode, 0);

      // R4: refused while disabled, refused off a boundary
      int_req_n = 1'b0; boundary = 1'b1; step;
      chk("R4 masked no ack", ack, 0);
      boundary = 1'b0; pulse_ei; step;
      chk("R4 no boundary no ack", ack, 0);
      int_req_n = 1'b1;

      // R4 + R7 restart 28h
      do_mi(8'hEF, a);
      chk("R4 ack", a, 1); chk("R4 take", take, 1); chk("R4 take_nmi", take_nmi, 0);
      chk("R4 ack gone", ack, 0); chk("R4 iff1", iff1, 0); chk("R4 iff2", iff2, 0);
      chk("R7 target", target, 16'h0028); chk("R7 good op", bad_op, 0);
      step; chk("R4 take pulse", take, 0);

      // R7 non-restart byte
      pulse_ei; do_mi(8'h3E, a);
      chk("R7 bad target", target, 16'h0038); chk("R7 bad flag", bad_op, 1);
      chk("R7 table", via_table, 0);

      // R5 mode 1 ignores the byte
      set_mode(1); pulse_ei; do_mi(8'hFF, a);
      chk("R5 target", target, 16'h0038); chk("R5 table", via_table, 0);
      chk("R5 bad", bad_op, 0);

      // R6 mode 2
      set_mode(2); page = 8'h12; pulse_ei; do_mi(8'h34, a);
      chk("R6 target", target, 16'h1234); chk("R6 table", via_table, 1);

      // random modes and bytes (R3/R5/R6/R7)
      void'($urandom(32'h5EED1));
      for (int i = 0; i < 40; i++) begin
         int m;
         logic [7:0] d;
         m = $urandom_range(0, 2);
         d = 8'($urandom);
         if (i % 3 == 0) d = d | 8'hC7;
         page = 8'($urandom);
         set_mode(m);
         pulse_ei;
         do_mi(d, a);
         chk(m == 2 ? "R6 rnd target" : (m == 1 ? "R5 rnd target" : "R7 rnd target"),
             target, exp_target(m, page, d));
         chk(m == 0 ? "R7 rnd bad" : "R5 rnd bad", bad_op, exp_bad(m, d));
         chk("R6 rnd table", via_table, m == 2);
      end

      // R8 NMI with enables on
      pulse_ei; do_nmi;
      chk("R8 take", take, 1); chk("R8 take_nmi", take_nmi, 1);
      chk("R8 target", target, 16'h0066); chk("R8 no ack", ack, 0);
      chk("R8 iff1", iff1, 0); chk("R8 iff2", iff2, 1);
      step; chk("R8 pulse end", take, 0);
      boundary = 1'b1; step; boundary = 1'b0;
      chk("R8 held low once", take, 0);
      nmi_n = 1'b1; step;

      // R9 return restores
      pulse_retn; chk("R9 iff1 restored", iff1, 1); chk("R9 iff2", iff2, 1);

      // R10 both pending: NMI wins, then maskable refused
      set_mode(1);
      nmi_n = 1'b0; int_req_n = 1'b0; step;
      boundary = 1'b1; step;
      chk("R10 nmi wins", take_nmi, 1); chk("R10 no ack", ack, 0);
      step;
      chk("R10 refused ack", ack, 0);
      boundary = 1'b0; int_req_n = 1'b1; nmi_n = 1'b1;
      step; chk("R10 refused take", take, 0);
      pulse_retn; chk("R10 retn iff1", iff1, 1);

      // R11 nested NMI loses the saved enable
      do_nmi; chk("R11 first iff2", iff2, 1);
      nmi_n = 1'b1; step;
      do_nmi; chk("R11 second iff2", iff2, 0); chk("R11 second take", take_nmi, 1);
      nmi_n = 1'b1; step;
      pulse_retn; chk("R11 retn iff1", iff1, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule